// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block sits between a 32-bit bus master and external devices whose data path may be 32, 16 or 8 bits wide. The master issues one word request. The adapter then runs one, two or four device cycles. Each device cycle opens with a one-clock strobe and ends when the device returns ready.

The device states its width on every clock through two active-low size inputs. Only the value present on the clock where ready is accepted decides how many bytes that device cycle moved. So a width can change partway through a transfer, and the adapter simply continues from the next byte still outstanding.

Bytes always travel on the low lanes. Lane k carries byte (offset + k) of the word, and the low address bits show the current offset. Read bytes are merged back into their proper places in a 32-bit result. Write data and even per-byte parity are driven only from the second clock of each device cycle. Transfers flagged as cache write-back ignore the size inputs and always complete in one full-width cycle.

Top module: `bus_width_adapter`

## Requirements
- R1: With both size inputs high at the accepted ready, a transfer from offset 0 completes in exactly one device cycle at byte address offset 0.
- R2: With only the 16-bit input low at each accepted ready, a transfer runs two device cycles, at byte offsets 0 and 2.
- R3: With only the 8-bit input low at each accepted ready, a transfer runs four device cycles, at byte offsets 0, 1, 2, 3 in that order.
- R4: When both size inputs are low at the accepted ready, 8-bit sizing applies: one byte moves in that cycle.
- R5: Size inputs on clocks where ready is low have no effect. Only the value sampled with the accepted ready sets how many bytes move.
- R6: A transfer flagged as write-back completes in one device cycle whatever the size inputs show.
- R7: During a write cycle at offset n, lane k of the write data carries byte n+k of the master word, for k < 4-n. Lanes at k >= 4-n are zero.
- R8: Write data and the data-drive flag are inactive (zero) on the strobe clock and while idle. They become active from the second clock of a write cycle until ready is accepted.
- R9: While write data is driven, parity bit k equals the XOR of the 8 bits of lane k (even parity). Otherwise all parity bits are zero.
- R10: On a read, byte n+k of the returned word is taken from lane k of the device data in the cycle at offset n. Lanes past the bytes moved are discarded.
- R11: The master done output pulses high for exactly one clock, on the clock after the last ready is accepted. The read result is valid while done is high.
- R12: Ready asserted on the strobe clock is ignored. A master request made while a transfer is in progress is ignored, and the address, direction and following transfers are unaffected.
- R13: During and after reset, with no request, the strobe, done, data-drive, write data and parity outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Master request, accepted when idle |
| m_we | input | 1 | Master direction: 1 write, 0 read |
| m_wb | input | 1 | Write-back transfer: size inputs ignored |
| m_waddr | input | ADDR_W-2 | Word address |
| m_wdata | input | DATA_W | Write word |
| m_done | output | 1 | One-clock completion pulse |
| m_rdata | output | DATA_W | Assembled read word |
| b_start | output | 1 | Device cycle strobe, first clock of each device cycle |
| b_addr | output | ADDR_W | Byte address, low bits give the current offset |
| b_we | output | 1 | Device cycle direction |
| b_wdrive | output | 1 | Write data is being driven |
| b_wdata | output | DATA_W | Steered write data |
| b_wpar | output | DATA_W/8 | Even parity per write lane |
| b_rdata | input | DATA_W | Device read data |
| b_rdy | input | 1 | Device ready |
| b_sz8_n | input | 1 | Active-low 8-bit device indication |
| b_sz16_n | input | 1 | Active-low 16-bit device indication |

## Verification
The hardest case to reach is a width that changes inside one transfer. For example, a device answers 8 bits at offset 0, 16 bits at offset 1 and 32 bits at offset 3, so the byte count is clipped at the word end. The stimulus vectors reach this by giving each device cycle its own size code.

A second difficult case is a size indication that differs between wait clocks and the ready clock. Wait cycles reach it by holding both size inputs low until the ready clock.

Read data outside the valid lanes is filled with a marker byte. A wrong merge therefore shows up in the assembled word.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_DATA   = 2'd2
  } seq_st_e;

  typedef enum logic [1:0] {
    DW_FULL = 2'd0,
    DW_HALF = 2'd1,
    DW_BYTE = 2'd2
  } dev_w_e;
endpackage

// File: rtl/bwa_size_sel.sv
module bwa_size_sel
  import bwa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic             sz8_n,
  input  logic             sz16_n,
  input  logic             wb,
  input  logic [OFF_W-1:0] off,
  output dev_w_e           dev_w,
  output logic [OFF_W:0]   nbytes,
  output logic             last
);
  localparam int CW = OFF_W + 1;

  logic [CW-1:0] remain;
  logic [CW-1:0] wbytes;

  always_comb begin
    remain = CW'(LANES) - CW'(off);
    if (wb) begin
      dev_w  = DW_FULL;
      wbytes = CW'(LANES);
    end else if (!sz8_n) begin
      dev_w  = DW_BYTE;
      wbytes = CW'(1);
    end else if (!sz16_n) begin
      dev_w  = DW_HALF;
      wbytes = CW'(2);
    end else begin
      dev_w  = DW_FULL;
      wbytes = CW'(LANES);
    end
    nbytes = (wbytes < remain) ? wbytes : remain;
    last   = (nbytes == remain);
  end
endmodule

// File: rtl/bwa_wr_steer.sv
module bwa_wr_steer #(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES),
  parameter int DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  output logic [DATA_W-1:0] lane_data,
  output logic [LANES-1:0]  lane_par
);
  logic [DATA_W-1:0] shifted;

  assign shifted   = word >> {off, 3'b000};
  assign lane_data = shifted;

  for (genvar k = 0; k < LANES; k++) begin : g_par
    assign lane_par[k] = ^shifted[8*k +: 8];
  end
endmodule

// File: rtl/bwa_rd_merge.sv
module bwa_rd_merge #(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES),
  parameter int DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W:0]    nbytes,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] shifted;
  logic [OFF_W:0]    lo;
  logic [OFF_W:0]    hi;
  logic [LANES-1:0]  take;

  assign shifted = rdata << {off, 3'b000};
  assign lo      = {1'b0, off};
  assign hi      = lo + nbytes;

  for (genvar j = 0; j < LANES; j++) begin : g_byte
    localparam logic [OFF_W:0] JV = (OFF_W+1)'(j);
    assign take[j]          = (JV >= lo) && (JV < hi);
    assign merged[8*j +: 8] = take[j] ? shifted[8*j +: 8] : acc[8*j +: 8];
  end
endmodule

// File: rtl/bwa_seq.sv
module bwa_seq
  import bwa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             rdy,
  input  logic             last,
  input  logic [OFF_W-1:0] step,
  output seq_st_e          st,
  output seq_st_e          st_nxt,
  output logic [OFF_W-1:0] off,
  output logic             accept,
  output logic             beat,
  output logic             finish
);
  always_comb begin
    st_nxt = st;
    accept = 1'b0;
    beat   = 1'b0;
    finish = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req) begin
          accept = 1'b1;
          st_nxt = ST_STROBE;
        end
      end
      ST_STROBE: st_nxt = ST_DATA;
      ST_DATA: begin
        if (rdy) begin
          beat = 1'b1;
          if (last) begin
            finish = 1'b1;
            st_nxt = ST_IDLE;
          end else begin
            st_nxt = ST_STROBE;
          end
        end
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      off <= '0;
    end else begin
      st <= st_nxt;
      if (accept)
        off <= '0;
      else if (beat && !last)
        off <= off + step;
    end
  end

  p_strobe_then_data_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STROBE) |=> (st == ST_DATA));

  p_offset_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (beat && !last) |=> (off != $past(off)));

  p_offset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    accept |=> (off == '0));
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    m_req,
  input  logic                    m_we,
  input  logic                    m_wb,
  input  logic [ADDR_W-OFF_W-1:0] m_waddr,
  input  logic [DATA_W-1:0]       m_wdata,
  output logic                    m_done,
  output logic [DATA_W-1:0]       m_rdata,
  output logic                    b_start,
  output logic [ADDR_W-1:0]       b_addr,
  output logic                    b_we,
  output logic                    b_wdrive,
  output logic [DATA_W-1:0]       b_wdata,
  output logic [LANES-1:0]        b_wpar,
  input  logic [DATA_W-1:0]       b_rdata,
  input  logic                    b_rdy,
  input  logic                    b_sz8_n,
  input  logic                    b_sz16_n
);
  seq_st_e st, st_nxt;
  dev_w_e  dev_w;

  logic [OFF_W-1:0]        off;
  logic [OFF_W:0]          nbytes;
  logic                    last, accept, beat, finish;
  logic [ADDR_W-OFF_W-1:0] addr_q;
  logic [DATA_W-1:0]       word_q, acc_q, rdata_q, merged;
  logic [DATA_W-1:0]       lane_data, wdata_q;
  logic [LANES-1:0]        lane_par, wpar_q;
  logic                    we_q, wb_q, done_q, start_q, wdrive_q;

  bwa_size_sel #(.LANES(LANES), .OFF_W(OFF_W)) u_size (
    .sz8_n (b_sz8_n),
    .sz16_n(b_sz16_n),
    .wb    (wb_q),
    .off   (off),
    .dev_w (dev_w),
    .nbytes(nbytes),
    .last  (last)
  );

  bwa_seq #(.LANES(LANES), .OFF_W(OFF_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .req   (m_req),
    .rdy   (b_rdy),
    .last  (last),
    .step  (nbytes[OFF_W-1:0]),
    .st    (st),
    .st_nxt(st_nxt),
    .off   (off),
    .accept(accept),
    .beat  (beat),
    .finish(finish)
  );

  bwa_wr_steer #(.LANES(LANES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_steer (
    .word     (word_q),
    .off      (off),
    .lane_data(lane_data),
    .lane_par (lane_par)
  );

  bwa_rd_merge #(.LANES(LANES), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_merge (
    .acc   (acc_q),
    .rdata (b_rdata),
    .off   (off),
    .nbytes(nbytes),
    .merged(merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      word_q   <= '0;
      we_q     <= 1'b0;
      wb_q     <= 1'b0;
      acc_q    <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
      start_q  <= 1'b0;
      wdrive_q <= 1'b0;
      wdata_q  <= '0;
      wpar_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= m_waddr;
        word_q <= m_wdata;
        we_q   <= m_we;
        wb_q   <= m_wb;
        acc_q  <= '0;
      end else if (beat) begin
        acc_q <= merged;
      end
      if (finish)
        rdata_q <= merged;
      done_q  <= finish;
      start_q <= (st_nxt == ST_STROBE);
      if (st_nxt == ST_DATA && we_q) begin
        wdrive_q <= 1'b1;
        wdata_q  <= lane_data;
        wpar_q   <= lane_par;
      end else begin
        wdrive_q <= 1'b0;
        wdata_q  <= '0;
        wpar_q   <= '0;
      end
    end
  end

  assign m_done   = done_q;
  assign m_rdata  = rdata_q;
  assign b_start  = start_q;
  assign b_addr   = {addr_q, off};
  assign b_we     = we_q;
  assign b_wdrive = wdrive_q;
  assign b_wdata  = wdata_q;
  assign b_wpar   = wpar_q;

  p_full_one_beat_r1: assert property (@(posedge clk) disable iff (rst)
    (beat && b_sz8_n && b_sz16_n && off == '0) |-> last);

  p_byte_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (beat && !wb_q && !b_sz8_n) |-> (dev_w == DW_BYTE && nbytes == 1));

  p_wb_single_r6: assert property (@(posedge clk) disable iff (rst)
    (beat && wb_q) |-> last);

  p_strobe_no_data_r8: assert property (@(posedge clk) disable iff (rst)
    b_start |-> (!b_wdrive && b_wdata == '0 && b_wpar == '0));

  p_quiet_parity_r9: assert property (@(posedge clk) disable iff (rst)
    !b_wdrive |-> (b_wpar == '0));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    m_done |=> !m_done);

  p_start_spaced_r12: assert property (@(posedge clk) disable iff (rst)
    b_start |=> !b_start);

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !b_wdrive);
endmodule

// File: tb/tb_bus_width_adapter.sv
module tb_bus_width_adapter;
  logic        clk = 1'b0;
  logic        rst;
  logic        m_req, m_we, m_wb;
  logic [29:0] m_waddr;
  logic [31:0] m_wdata;
  logic        m_done;
  logic [31:0] m_rdata;
  logic        b_start, b_we, b_wdrive;
  logic [31:0] b_addr, b_wdata, b_rdata;
  logic [3:0]  b_wpar;
  logic        b_rdy, b_sz8_n, b_sz16_n;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  bus_width_adapter dut (
    .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_wb(m_wb),
    .m_waddr(m_waddr), .m_wdata(m_wdata), .m_done(m_done), .m_rdata(m_rdata),
    .b_start(b_start), .b_addr(b_addr), .b_we(b_we), .b_wdrive(b_wdrive),
    .b_wdata(b_wdata), .b_wpar(b_wpar), .b_rdata(b_rdata), .b_rdy(b_rdy),
    .b_sz8_n(b_sz8_n), .b_sz16_n(b_sz16_n)
  );

  // {beats[4], we, wb, waits[2], size codes[8] (cycle 0 in [1:0]), addr[32], data[32]}
  // size code: 0 none low, 1 16-bit low, 2 8-bit low, 3 both low
  localparam int NV = 14;
  localparam logic [79:0] VEC [NV] = '{
    {4'd1, 1'b0, 1'b0, 2'd0, 8'h00, 32'h0000_1000, 32'hA1B2_C3D4},
    {4'd1, 1'b1, 1'b0, 2'd0, 8'h00, 32'h0000_2004, 32'h1234_5678},
    {4'd2, 1'b0, 1'b0, 2'd0, 8'h05, 32'h0000_3008, 32'hCAFE_BABE},
    {4'd2, 1'b1, 1'b0, 2'd0, 8'h05, 32'h4000_000C, 32'h0F0F_F0F1},
    {4'd4, 1'b0, 1'b0, 2'd0, 8'hAA, 32'h0000_5010, 32'h89AB_CDEF},
    {4'd4, 1'b1, 1'b0, 2'd0, 8'hAA, 32'h0000_6014, 32'h8001_7F3C},
    {4'd4, 1'b0, 1'b0, 2'd0, 8'hFF, 32'h0000_7018, 32'h5A5A_A5A5},
    {4'd3, 1'b0, 1'b0, 2'd0, 8'h29, 32'h0000_801C, 32'h1357_9BDF},
    {4'd3, 1'b1, 1'b0, 2'd0, 8'h06, 32'h0000_9020, 32'hFEDC_BA98},
    {4'd1, 1'b1, 1'b1, 2'd0, 8'h02, 32'h0000_A024, 32'h7766_5544},
    {4'd1, 1'b0, 1'b1, 2'd0, 8'h03, 32'h0000_B028, 32'h0102_0304},
    {4'd1, 1'b0, 1'b0, 2'd2, 8'h00, 32'h0000_C02C, 32'hDEAD_BEEF},
    {4'd2, 1'b1, 1'b0, 2'd1, 8'h05, 32'h0000_D030, 32'h3C3C_00FF},
    {4'd4, 1'b1, 1'b0, 2'd3, 8'hAA, 32'h0000_E034, 32'hA5C3_E187}
  };

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] par4(input logic [31:0] w);
    for (int k = 0; k < 4; k++) par4[k] = ^w[8*k +: 8];
  endfunction

  function automatic string tag_of(input logic wb, input logic [1:0] waits,
                                   input logic [1:0] code);
    if (wb) return "R6";
    if (waits != 0) return "R5";
    case (code)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic set_size(input logic [1:0] code);
    b_sz8_n  = !(code == 2'd2 || code == 2'd3);
    b_sz16_n = !(code == 2'd1 || code == 2'd3);
  endtask

  task automatic run_xfer(input logic [3:0] nbeats, input logic we, input logic wb,
                          input logic [1:0] waits, input logic [7:0] codes,
                          input logic [31:0] addr, input logic [31:0] data,
                          input bit early_rdy, input bit busy_req);
    int off = 0;
    int beats = 0;
    int strobes = 0;
    @(negedge clk);
    m_req = 1'b1; m_we = we; m_wb = wb; m_waddr = addr[31:2]; m_wdata = data;
    @(negedge clk);
    m_req = 1'b0; m_waddr = 30'h2AAA_AAAA; m_wdata = 32'h0; m_we = !we;
    while (off < 4 && beats < 4) begin
      logic [1:0] code;
      string tg;
      logic [31:0] exp_w, rd;
      int width, n;
      code = codes[2*beats +: 2];
      tg = tag_of(wb, waits, code);
      if (b_start) strobes++;
      chk(b_start == 1'b1, tg, {31'b0, b_start}, 32'd1);
      chk(b_addr == addr + off, tg, b_addr, addr + off);
      chk(b_we == we, "R12", {31'b0, b_we}, {31'b0, we});
      chk(!b_wdrive && b_wdata == 0 && b_wpar == 0, "R8", b_wdata, 32'h0);
      if (early_rdy && beats == 0) begin
        b_rdy = 1'b1; set_size(2'd0); b_rdata = 32'h0BAD_0BAD;
      end
      @(negedge clk);
      b_rdy = 1'b0; b_rdata = 32'h0;
      if (early_rdy && beats == 0)
        chk(!b_start && !m_done, "R12", {31'b0, m_done}, 32'h0);
      exp_w = data >> (8 * off);
      for (int w = 0; w <= int'(waits); w++) begin
        if (w < int'(waits)) begin
          b_sz8_n = 1'b0; b_sz16_n = 1'b0;
        end
        if (we) begin
          chk(b_wdrive == 1'b1, "R8", {31'b0, b_wdrive}, 32'd1);
          chk(b_wdata == exp_w, "R7", b_wdata, exp_w);
          chk(b_wpar == par4(exp_w), "R9", {28'b0, b_wpar}, {28'b0, par4(exp_w)});
        end else begin
          chk(!b_wdrive && b_wdata == 0 && b_wpar == 0, "R8", b_wdata, 32'h0);
        end
        if (w < int'(waits)) begin
          @(negedge clk);
          chk(!b_start && !m_done, "R5", {31'b0, b_start}, 32'h0);
        end
      end
      b_rdy = 1'b1;
      set_size(code);
      rd = data >> (8 * off);
      for (int k = 0; k < 4; k++)
        if (k >= 4 - off) rd[8*k +: 8] = 8'hEE;
      b_rdata = rd;
      if (busy_req && beats == 0) begin
        m_req = 1'b1; m_waddr = 30'h1555_5555; m_we = !we;
      end
      width = wb ? 4 : (code == 2'd0 ? 4 : (code == 2'd1 ? 2 : 1));
      n = (width < 4 - off) ? width : 4 - off;
      off += n;
      beats++;
      @(negedge clk);
      b_rdy = 1'b0; m_req = 1'b0; b_sz8_n = 1'b1; b_sz16_n = 1'b1; b_rdata = 32'h0;
      if (off < 4)
        chk(b_start && !m_done, tg, {31'b0, m_done}, 32'h0);
      else
        chk(m_done && !b_start, "R11", {31'b0, m_done}, 32'd1);
    end
    chk(strobes == int'(nbeats), tag_of(wb, waits, codes[1:0]), strobes, {28'b0, nbeats});
    if (!we) chk(m_rdata == data, "R10", m_rdata, data);
    @(negedge clk);
    chk(!m_done, "R11", {31'b0, m_done}, 32'h0);
    chk(!b_start, "R12", {31'b0, b_start}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog: transfer never completed actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; m_req = 1'b1; m_we = 1'b1; m_wb = 1'b0; m_waddr = '0;
    m_wdata = 32'hFFFF_FFFF; b_rdata = '0; b_rdy = 1'b0;
    b_sz8_n = 1'b1; b_sz16_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!b_start && !m_done && !b_wdrive, "R13", {29'b0, b_start, m_done, b_wdrive}, 32'h0);
    chk(b_wdata == 0 && b_wpar == 0, "R13", b_wdata, 32'h0);
    m_req = 1'b0;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!b_start && !m_done && !b_wdrive, "R13", {29'b0, b_start, m_done, b_wdrive}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      v = VEC[i];
      run_xfer(v[79:76], v[75], v[74], v[73:72], v[71:64], v[63:32], v[31:0], 1'b0, 1'b0);
    end

    // R12: ready during the strobe clock must not end the device cycle
    run_xfer(4'd1, 1'b0, 1'b0, 2'd0, 8'h00, 32'h0000_F000, 32'h6B6B_1234, 1'b1, 1'b0);
    // R12: request while busy is ignored
    run_xfer(4'd2, 1'b1, 1'b0, 2'd0, 8'h05, 32'h0000_F104, 32'h9A8B_7C6D, 1'b0, 1'b1);
    run_xfer(4'd4, 1'b0, 1'b0, 2'd0, 8'hAA, 32'h0000_F208, 32'h4433_2211, 1'b0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule